// File: doc/BRIEF.md
# Byte-to-Halfword Unpacking Load Extender

This block sits in the data return path of a load pipeline. Each cycle it takes the 64-bit beat that memory returned, picks a group of consecutive bytes from that beat, and widens each byte into its own 16-bit halfword lane of a packed result. It widens with zeros or by copying the byte's top bit, as the sign select asks. It has two forms. The pair form takes two bytes and yields a 32-bit result in the low half of the output. The quad form takes four bytes and yields a full 64-bit result.

The byte offset gives the position of the group's first byte inside the beat. An offset that is not a multiple of the access size raises an error flag and produces an all-zero result. The widening logic is combinational, and one output register registers the result, so each result appears one clock after its inputs.

Top module: `lx_unpack`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state is unpacked = 0 and misalign = 0.
- R2: The outputs reflect the inputs sampled at the previous rising edge of clk: one cycle of latency, and no combinational path from input to output.
- R3: Byte k of raw_beat is raw_beat[8k+7:8k]. The byte at index byte_off goes into lane 0, unpacked[15:0]. The byte at byte_off+i goes into lane i, unpacked[16i+15:16i].
- R4: With sign_ext = 0, bits [15:8] of every lane are zero and bits [7:0] hold the byte.
- R5: With sign_ext = 1, bits [15:8] of each active lane are copies of bit 7 of that lane's byte, so 0x81 becomes 0xFF81 and 0x02 becomes 0x0002.
- R6: With quad_sel = 0 (pair form), two bytes fill lanes 0 and 1, and unpacked[63:32] is zero.
- R7: With quad_sel = 1 (quad form), four bytes fill lanes 0 to 3. For bytes 0x81, 0x02, 0x83, 0x04 at offset 0, the zero-extended result is 0x0004_0083_0002_0081 and the sign-extended result is 0x0004_FF83_0002_FF81.
- R8: Every aligned group in the beat can be selected. In pair form the offsets are 0, 2, 4 and 6. In quad form the offsets are 0 and 4.
- R9: misalign is 1 when byte_off is odd in pair form, or when byte_off[1:0] is not 0 in quad form. Whenever misalign is 1, unpacked is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_beat | input | 64 | Beat returned by memory, byte k at bits [8k+7:8k] |
| quad_sel | input | 1 | 0: pair form (2 bytes), 1: quad form (4 bytes) |
| sign_ext | input | 1 | 0: zero extension, 1: sign extension |
| byte_off | input | 3 | Offset of the first byte within the beat |
| unpacked | output | 64 | Packed halfword lanes, registered |
| misalign | output | 1 | Offset not a multiple of the access size, registered |

## Verification
The bench sweeps every byte value in both extension modes, on both forms and at every legal offset, with distinct neighbouring bytes. A design that tested the wrong bit for sign, or picked a byte off by one position, would show wrong high bytes or values borrowed from a neighbour. The pair form is checked to leave the upper 32 bits clear, which catches lanes 2 and 3 leaking through. Misaligned offsets are driven in both forms, and each must raise the flag with a zero result; a checker that used the wrong mask would let one form pass silently. Reset in mid-stream and the one-cycle latency are also checked, so that a result appearing early or surviving a reset is caught.

// File: rtl/lx_pkg.sv
// Shared parameters and types for the unpacking load extender.
package lx_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int BYTE_W     = 8;
    localparam int LANE_W     = 16;
    localparam int MAX_ELEMS  = 4;
    localparam int OFF_W      = $clog2(BEAT_BYTES);

    typedef enum logic {
        FORM_PAIR = 1'b0,
        FORM_QUAD = 1'b1
    } form_e;
endpackage

// File: rtl/lx_byte_shifter.sv
// Byte-lane shifter: presents OUT_BYTES consecutive bytes of the beat,
// starting at byte index off, as a small window.
// Assumes: any window byte past the end of the beat reads as zero.
module lx_byte_shifter #(
    parameter int BEAT_BYTES = 8,
    parameter int BYTE_W     = 8,
    parameter int OUT_BYTES  = 4,
    parameter int OFF_W      = 3
) (
    input  logic [BEAT_BYTES*BYTE_W-1:0] beat,
    input  logic [OFF_W-1:0]             off,
    output logic [OUT_BYTES*BYTE_W-1:0]  window
);
    // Pick each window byte from its position in the beat.
    always_comb begin
        window = '0;
        for (int j = 0; j < OUT_BYTES; j++) begin
            for (int k = 0; k < BEAT_BYTES; k++) begin
                if (int'(off) + j == k)
                    window[j*BYTE_W +: BYTE_W] = beat[k*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/lx_lane_extender.sv
// Lane extender: widens each window byte into its own halfword lane.
// A disabled lane is driven to zero.
// Assumes: lane_en is a contiguous mask starting at lane 0.
module lx_lane_extender #(
    parameter int N_LANES = 4,
    parameter int BYTE_W  = 8,
    parameter int LANE_W  = 16
) (
    input  logic [N_LANES*BYTE_W-1:0] bytes_in,
    input  logic                      sign_ext,
    input  logic [N_LANES-1:0]        lane_en,
    output logic [N_LANES*LANE_W-1:0] lanes
);
    localparam int EXT_W = LANE_W - BYTE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] b;
        logic              fill;
        assign b    = bytes_in[i*BYTE_W +: BYTE_W];
        assign fill = sign_ext & b[BYTE_W-1];
        // Form one lane: fill bits on top of the byte, or zero when disabled.
        always_comb begin
            lanes[i*LANE_W +: LANE_W] = lane_en[i] ? {{EXT_W{fill}}, b} : '0;
        end
    end
endmodule

// File: rtl/lx_align_check.sv
// Alignment checker: flags an offset that is not a multiple of the access
// size. The access size is MAX_ELEMS bytes in quad form and half of that
// in pair form.
// Assumes: MAX_ELEMS is a power of two.
module lx_align_check #(
    parameter int OFF_W     = 3,
    parameter int MAX_ELEMS = 4
) (
    input  logic [OFF_W-1:0] off,
    input  logic             quad,
    output logic             bad
);
    localparam logic [OFF_W-1:0] QUAD_MASK = OFF_W'(MAX_ELEMS - 1);
    localparam logic [OFF_W-1:0] PAIR_MASK = OFF_W'(MAX_ELEMS / 2 - 1);

    // Any offset bit below the access size marks the access misaligned.
    always_comb begin
        bad = |(off & (quad ? QUAD_MASK : PAIR_MASK));
    end
endmodule

// File: rtl/lx_unpack.sv
// Unpacking load extender top. It shifts the addressed bytes out of the
// beat, widens each into a halfword lane and registers the result.
// Misaligned accesses yield a zero result with misalign set.
// Assumes: raw_beat, quad_sel, sign_ext and byte_off are valid each cycle.
module lx_unpack
    import lx_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BEAT_BYTES*BYTE_W-1:0] raw_beat,
    input  logic                        quad_sel,
    input  logic                        sign_ext,
    input  logic [OFF_W-1:0]            byte_off,
    output logic [MAX_ELEMS*LANE_W-1:0] unpacked,
    output logic                        misalign
);
    localparam int PAIR_ELEMS = MAX_ELEMS / 2;
    localparam int OUT_W      = MAX_ELEMS * LANE_W;

    form_e                       form;
    logic [MAX_ELEMS*BYTE_W-1:0] window;
    logic [MAX_ELEMS-1:0]        lane_en;
    logic [OUT_W-1:0]            lanes;
    logic                        bad;

    assign form = form_e'(quad_sel);

    // Enable the low lanes that this form uses.
    always_comb begin
        for (int i = 0; i < MAX_ELEMS; i++)
            lane_en[i] = (form == FORM_QUAD) ? 1'b1 : (i < PAIR_ELEMS);
    end

    lx_byte_shifter #(
        .BEAT_BYTES(BEAT_BYTES), .BYTE_W(BYTE_W),
        .OUT_BYTES(MAX_ELEMS),   .OFF_W(OFF_W)
    ) u_shift (
        .beat(raw_beat), .off(byte_off), .window(window)
    );

    lx_lane_extender #(
        .N_LANES(MAX_ELEMS), .BYTE_W(BYTE_W), .LANE_W(LANE_W)
    ) u_ext (
        .bytes_in(window), .sign_ext(sign_ext), .lane_en(lane_en), .lanes(lanes)
    );

    lx_align_check #(
        .OFF_W(OFF_W), .MAX_ELEMS(MAX_ELEMS)
    ) u_align (
        .off(byte_off), .quad(quad_sel), .bad(bad)
    );

    // Output register: clear on reset, zero data on a misaligned access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unpacked <= '0;
            misalign <= 1'b0;
        end else begin
            unpacked <= bad ? '0 : lanes;
            misalign <= bad;
        end
    end

    // R6: pair form leaves the upper half clear
    a_r6_pair_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(quad_sel)) |-> (unpacked[OUT_W-1:OUT_W/2] == '0));

    // R9: misaligned offset raises the flag
    a_r9_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(quad_sel) && ($past(byte_off[1:0]) != 2'b00)) |-> misalign);

    // R9: a flagged access carries a zero result
    a_r9_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (unpacked == '0));

    // R4: zero extension leaves every high byte clear
    a_r4_unsigned_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sign_ext)) |-> ((unpacked & {MAX_ELEMS{16'hFF00}}) == '0));

    for (genvar i = 0; i < MAX_ELEMS; i++) begin : g_chk
        // R5: sign extension copies bit 7 into the high byte of each lane
        a_r5_signed_fill: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sign_ext)) |->
            (unpacked[i*LANE_W+BYTE_W +: BYTE_W] == {BYTE_W{unpacked[i*LANE_W+BYTE_W-1]}}));
    end
endmodule

// File: tb/tb_lx_unpack.sv
module tb_lx_unpack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] raw_beat = '0;
    logic        quad_sel = 1'b0;
    logic        sign_ext = 1'b0;
    logic [2:0]  byte_off = '0;
    logic [63:0] unpacked;
    logic        misalign;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lx_unpack dut (
        .clk(clk), .rst_n(rst_n), .raw_beat(raw_beat), .quad_sel(quad_sel),
        .sign_ext(sign_ext), .byte_off(byte_off), .unpacked(unpacked), .misalign(misalign)
    );

    // Entry: {raw, quad, sign, off, expected data, expected flag}
    localparam logic [63:0] BEAT = 64'h0887_0685_0483_0281;
    localparam int NT = 11;
    localparam logic [133:0] TBL [0:NT-1] = '{
        {BEAT, 1'b1, 1'b0, 3'd0, 64'h0004_0083_0002_0081, 1'b0},
        {BEAT, 1'b1, 1'b1, 3'd0, 64'h0004_FF83_0002_FF81, 1'b0},
        {BEAT, 1'b1, 1'b0, 3'd4, 64'h0008_0087_0006_0085, 1'b0},
        {BEAT, 1'b1, 1'b1, 3'd4, 64'h0008_FF87_0006_FF85, 1'b0},
        {BEAT, 1'b0, 1'b0, 3'd0, 64'h0000_0000_0002_0081, 1'b0},
        {BEAT, 1'b0, 1'b1, 3'd2, 64'h0000_0000_0004_FF83, 1'b0},
        {BEAT, 1'b0, 1'b1, 3'd6, 64'h0000_0000_0008_FF87, 1'b0},
        {BEAT, 1'b0, 1'b1, 3'd4, 64'h0000_0000_0006_FF85, 1'b0},
        {BEAT, 1'b0, 1'b0, 3'd3, 64'h0, 1'b1},
        {BEAT, 1'b1, 1'b1, 3'd2, 64'h0, 1'b1},
        {BEAT, 1'b1, 1'b0, 3'd6, 64'h0, 1'b1}
    };

    function automatic logic [63:0] ref_model(input logic [63:0] raw, input logic q,
                                              input logic s, input logic [2:0] off,
                                              output logic err);
        logic [63:0] r = '0;
        int n = q ? 4 : 2;
        err = q ? (off[1:0] != 2'b00) : off[0];
        if (!err) begin
            for (int i = 0; i < n; i++) begin
                logic [7:0] b = raw[8*(int'(off)+i) +: 8];
                r[16*i +: 16] = s ? {{8{b[7]}}, b} : {8'h00, b};
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] exp_d, input logic exp_e);
        n_vec++;
        if (unpacked !== exp_d || misalign !== exp_e) begin
            n_bad++;
            $display("FAIL %s: got data=%h flag=%b, expected data=%h flag=%b",
                     tag, unpacked, misalign, exp_d, exp_e);
        end
    endtask

    task automatic apply(input logic [63:0] raw, input logic q, input logic s,
                         input logic [2:0] off);
        @(negedge clk);
        raw_beat = raw; quad_sel = q; sign_ext = s; byte_off = off;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] e;
        logic        ee;
        repeat (3) @(negedge clk);
        check("R1 reset state", 64'h0, 1'b0);
        rst_n = 1'b1;

        // Vector table
        for (int t = 0; t < NT; t++) begin
            apply(TBL[t][133:70], TBL[t][69], TBL[t][68], TBL[t][67:65]);
            check(TBL[t][0] ? "R9 table" : (TBL[t][69] ? "R7 table" : "R6 table"),
                  TBL[t][64:1], TBL[t][0]);
        end

        // R3 lane order with distinct bytes
        apply(64'h7766_5544_3322_1100, 1'b1, 1'b0, 3'd0);
        check("R3 lane order", 64'h0033_0022_0011_0000, 1'b0);

        // Exhaustive byte sweep, both modes, all legal groups (R4, R5, R8)
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
                for (int g = 0; g < 6; g++) begin
                    logic [63:0] raw;
                    logic q = (g >= 4);
                    logic [2:0] off = q ? 3'(4 * (g - 4)) : 3'(2 * g);
                    for (int k = 0; k < 8; k++) raw[8*k +: 8] = 8'(v + 37 * k);
                    raw[8*int'(off) +: 8] = 8'(v);
                    apply(raw, q, s[0], off);
                    e = ref_model(raw, q, s[0], off, ee);
                    check(s ? "R5 R8 sweep" : "R4 R8 sweep", e, ee);
                end
            end
        end

        // R2 latency: output holds the old result until the next edge
        apply(BEAT, 1'b1, 1'b1, 3'd0);
        @(negedge clk);
        raw_beat = 64'h0; quad_sel = 1'b0; sign_ext = 1'b0; byte_off = 3'd2;
        #1;
        check("R2 before edge", 64'h0004_FF83_0002_FF81, 1'b0);
        @(negedge clk);
        check("R2 after edge", 64'h0, 1'b0);

        // R1 mid-stream reset clears a live result and flag
        apply(BEAT, 1'b0, 1'b0, 3'd1);
        check("R9 pair odd", 64'h0, 1'b1);
        apply(BEAT, 1'b1, 1'b1, 3'd4);
        @(negedge clk);
        rst_n = 1'b0;
        byte_off = 3'd1;
        @(negedge clk);
        check("R1 mid reset", 64'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule